// File: doc/BRIEF.md
# Speculative Block Address Lookup Table

This block is a small, fully associative table that records which cache blocks have been touched by memory operations that retired speculatively into a history queue. It keeps each block once, no matter how many speculative loads and stores hit it. Each entry holds the queue index of the oldest access, the queue index of the youngest access, and a flag that says whether any of those accesses was a store.

Coherence events from the second-level cache probe the table in the cycle they arrive. These events are invalidations, replacements, downgrades and external reads. A probe that hits raises a rollback request that carries the queue index of the oldest instruction that touched the block. On the clock edge that ends a rollback cycle, the table removes every entry whose oldest access is at or after the rollback target. An entry that straddles the target keeps its older part.

As the history queue drains in order, the release port retires queue indices one at a time. An entry is freed when the index of its youngest access drains. When every slot is in use, the table raises `full`, and the requester must hold back further speculative retirement.

Top module: `spec_block_table`

## Requirements
- R1: Accesses whose addresses differ only in the low BLK_BITS bits (same block) share one entry; a repeat insert of a resident block does not use a new slot.
- R2: A probe of kind 0 (invalidation) or kind 1 (replacement) hits any valid entry of the same block, whether it was loaded or stored.
- R3: A probe of kind 2 (downgrade) or kind 3 (external read) hits only an entry whose stored flag is set; for a block that was only loaded it raises no rollback.
- R4: On a hit, `rb_idx` equals the queue index of the first insert of that block since the entry was allocated.
- R5: An insert with `ins_store` high to a block that is already resident sets that entry's stored flag.
- R6: A release whose index equals an entry's youngest recorded index frees that entry. A release of any other index leaves the entry resident.
- R7: `full` is high exactly when every slot is valid. An insert of a new block while `full` is high is dropped, so the table keeps its contents.
- R8: Ages are measured as (index − oldest undrained index) modulo 2^IDX_W. On a rollback to target T, every entry whose oldest index is as young as T or younger is removed. Any other entry whose youngest index is as young as T or younger has its youngest index set to T−1.
- R9: After reset the table is empty: `full` and `rb_valid` are low, and no probe hits.
- R10: `rb_valid` depends combinationally on the probe in the same cycle and is never high while `prb_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Record a speculative access |
| ins_addr | input | ADDR_W | Byte address of the access |
| ins_store | input | 1 | Access is a store |
| ins_idx | input | IDX_W | History queue index of the access |
| prb_valid | input | 1 | Coherence event present |
| prb_addr | input | ADDR_W | Byte address of the event |
| prb_kind | input | 2 | 0 invalidate, 1 replace, 2 downgrade, 3 external read |
| rel_valid | input | 1 | Queue entry drained |
| rel_idx | input | IDX_W | Index of the drained queue entry |
| rb_valid | output | 1 | Rollback request |
| rb_idx | output | IDX_W | Queue index to roll back to |
| full | output | 1 | No free slot |

## Verification
A wrong stored flag or a lost entry shows up only when a probe arrives. The symptom is a missing or extra `rb_valid` in that same probe cycle. A bad oldest index shows up as a wrong `rb_idx` on the next hit to that block. A wrong youngest index shows up later: the entry is freed too early, which makes a later probe miss, or it is never freed, which makes `full` stay high. The bench therefore follows every rollback and every release with probes of both the removed blocks and the surviving blocks, so that each of these errors appears within a few cycles.

// File: rtl/spec_block_table.sv
module spec_block_table #(
  parameter int ENTRIES  = 64,
  parameter int ADDR_W   = 48,
  parameter int BLK_BITS = 6,
  parameter int IDX_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic              ins_store,
  input  logic [IDX_W-1:0]  ins_idx,
  input  logic              prb_valid,
  input  logic [ADDR_W-1:0] prb_addr,
  input  logic [1:0]        prb_kind,
  input  logic              rel_valid,
  input  logic [IDX_W-1:0]  rel_idx,
  output logic              rb_valid,
  output logic [IDX_W-1:0]  rb_idx,
  output logic              full
);
  localparam int TAG_W = ADDR_W - BLK_BITS;

  logic [ENTRIES-1:0] vld, st;
  logic [TAG_W-1:0]   tag   [ENTRIES];
  logic [IDX_W-1:0]   old_q [ENTRIES];
  logic [IDX_W-1:0]   yng_q [ENTRIES];
  logic [IDX_W-1:0]   head;

  logic [TAG_W-1:0]   ins_tag, prb_tag;
  logic [ENTRIES-1:0] ins_hit, prb_match, prb_hit, rel_free, alloc, kill, trim;
  logic               ins_any;
  logic [IDX_W-1:0]   rb_age;

  assign ins_tag  = ins_addr[ADDR_W-1:BLK_BITS];
  assign prb_tag  = prb_addr[ADDR_W-1:BLK_BITS];
  assign ins_any  = |ins_hit;
  assign full     = &vld;
  assign rb_valid = prb_valid && (|prb_hit);
  assign rb_age   = rb_idx - head;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_ent
      assign ins_hit[g]   = vld[g] && (tag[g] == ins_tag);
      assign prb_match[g] = vld[g] && (tag[g] == prb_tag);
      assign prb_hit[g]   = prb_match[g] && (!prb_kind[1] || st[g]);
      assign rel_free[g]  = rel_valid && vld[g] && (yng_q[g] == rel_idx);
      assign kill[g]      = IDX_W'(old_q[g] - head) >= rb_age;
      assign trim[g]      = IDX_W'(yng_q[g] - head) >= rb_age;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          vld[g] <= 1'b0;
          st[g]  <= 1'b0;
        end else if (rb_valid) begin
          if (rel_free[g] || kill[g]) vld[g] <= 1'b0;
          else if (trim[g]) yng_q[g] <= rb_idx - 1'b1;
        end else begin
          if (rel_free[g]) vld[g] <= 1'b0;
          if (ins_valid && ins_hit[g]) begin
            yng_q[g] <= ins_idx;
            if (rel_free[g]) begin
              vld[g]   <= 1'b1;
              old_q[g] <= ins_idx;
              st[g]    <= ins_store;
            end else begin
              st[g] <= st[g] | ins_store;
            end
          end else if (ins_valid && !ins_any && alloc[g]) begin
            vld[g]   <= 1'b1;
            tag[g]   <= ins_tag;
            old_q[g] <= ins_idx;
            yng_q[g] <= ins_idx;
            st[g]    <= ins_store;
          end
        end
      end
    end
  endgenerate

  always_comb begin
    alloc = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld[i]) begin
        alloc    = '0;
        alloc[i] = 1'b1;
      end
    end
  end

  always_comb begin
    rb_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (prb_hit[i]) rb_idx = rb_idx | old_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) head <= '0;
    else if (rel_valid) head <= rel_idx + 1'b1;
  end
endmodule

// File: rtl/spec_block_table_chk.sv
module spec_block_table_chk #(
  parameter int ENTRIES  = 64,
  parameter int ADDR_W   = 48,
  parameter int BLK_BITS = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ins_valid,
  input logic               prb_valid,
  input logic [ADDR_W-1:0]  prb_addr,
  input logic [1:0]         prb_kind,
  input logic               rb_valid,
  input logic [ENTRIES-1:0] vld,
  input logic [ENTRIES-1:0] st,
  input logic [ENTRIES-1:0] prb_match
);
  // R10
  rb_needs_probe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rb_valid |-> prb_valid);

  // R1
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(prb_match));

  // R3
  read_hit_stored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_valid && prb_kind[1]) |-> (|(prb_match & st)));

  // R8
  no_rehit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rb_valid) && !$past(ins_valid) && prb_valid &&
     prb_addr[ADDR_W-1:BLK_BITS] == $past(prb_addr[ADDR_W-1:BLK_BITS])) |-> !rb_valid);

  // R9
  reset_empty_chk: assert property (@(posedge clk)
    !rst_n |=> (vld == '0));
endmodule

bind spec_block_table spec_block_table_chk #(
  .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .BLK_BITS(BLK_BITS)
) i_chk (
  .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .prb_valid(prb_valid),
  .prb_addr(prb_addr), .prb_kind(prb_kind), .rb_valid(rb_valid),
  .vld(vld), .st(st), .prb_match(prb_match)
);

// File: tb/test_spec_block_table.sv
module test_spec_block_table;
  localparam int E = 4, AW = 16, BB = 6, IW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ins_valid = 0, ins_store = 0, prb_valid = 0, rel_valid = 0;
  logic [AW-1:0] ins_addr = '0, prb_addr = '0;
  logic [IW-1:0] ins_idx = '0, rel_idx = '0;
  logic [1:0] prb_kind = '0;
  logic rb_valid, full;
  logic [IW-1:0] rb_idx;

  always #2 clk = ~clk;

  spec_block_table #(.ENTRIES(E), .ADDR_W(AW), .BLK_BITS(BB), .IDX_W(IW)) i_spec_block_table (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_addr(ins_addr),
    .ins_store(ins_store), .ins_idx(ins_idx), .prb_valid(prb_valid),
    .prb_addr(prb_addr), .prb_kind(prb_kind), .rel_valid(rel_valid),
    .rel_idx(rel_idx), .rb_valid(rb_valid), .rb_idx(rb_idx), .full(full));

  int vectors = 0, miscompares = 0;
  bit done = 0;

  bit m_v[E], m_s[E];
  logic [AW-BB-1:0] m_t[E];
  logic [IW-1:0] m_o[E], m_y[E];
  logic [IW-1:0] mhead = '0, nxt = '0;
  bit last_hit;
  logic [IW-1:0] last_idx;

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic int mcount();
    int c = 0;
    for (int i = 0; i < E; i++) if (m_v[i]) c++;
    return c;
  endfunction

  task automatic do_insert(logic [AW-1:0] a, bit s);
    int hit = -1, fr = -1;
    @(negedge clk);
    ins_valid = 1; ins_addr = a; ins_store = s; ins_idx = nxt;
    for (int i = 0; i < E; i++) if (m_v[i] && m_t[i] == a[AW-1:BB]) hit = i;
    for (int i = E - 1; i >= 0; i--) if (!m_v[i]) fr = i;
    if (hit >= 0) begin
      m_y[hit] = nxt; m_s[hit] = m_s[hit] | s;
    end else if (fr >= 0) begin
      m_v[fr] = 1; m_t[fr] = a[AW-1:BB]; m_o[fr] = nxt; m_y[fr] = nxt; m_s[fr] = s;
    end
    @(posedge clk); #1;
    ins_valid = 0;
    nxt = nxt + 1'b1;
  endtask

  task automatic do_release();
    @(negedge clk);
    rel_valid = 1; rel_idx = mhead;
    for (int i = 0; i < E; i++) if (m_v[i] && m_y[i] == mhead) m_v[i] = 0;
    @(posedge clk); #1;
    rel_valid = 0;
    mhead = mhead + 1'b1;
  endtask

  task automatic do_probe(logic [AW-1:0] a, logic [1:0] k, string r);
    bit eh = 0;
    logic [IW-1:0] et = '0, ta;
    @(negedge clk);
    prb_valid = 1; prb_addr = a; prb_kind = k;
    for (int i = 0; i < E; i++)
      if (m_v[i] && m_t[i] == a[AW-1:BB] && (!k[1] || m_s[i])) begin eh = 1; et = m_o[i]; end
    #1;
    chk(r, rb_valid, eh);
    if (eh) chk(r, rb_idx, et);
    last_hit = rb_valid; last_idx = rb_idx;
    @(posedge clk); #1;
    prb_valid = 0;
    if (eh) begin
      ta = et - mhead;
      for (int i = 0; i < E; i++) if (m_v[i]) begin
        if (IW'(m_o[i] - mhead) >= ta) m_v[i] = 0;
        else if (IW'(m_y[i] - mhead) >= ta) m_y[i] = et - 1'b1;
      end
      nxt = et;
    end
    chk("R7 full", full, mcount() == E);
  endtask

  localparam logic [AW-1:0] A = 16'h0100, B = 16'h0200, C = 16'h0300,
                            D = 16'h0400, F5 = 16'h0500, F6 = 16'h0600, G = 16'h0700;

  initial begin
    #(200000 * 4);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf = 16'hACE1;
    for (int i = 0; i < E; i++) begin m_v[i] = 0; m_s[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk("R9 full after reset", full, 0);
    do_probe(A, 0, "R9 empty probe");
    chk("R9 no hit", last_hit, 0);

    do_insert(A, 0);
    do_probe(A + 3, 3, "R3 load-only ext read");
    chk("R3 miss", last_hit, 0);
    do_probe(A, 2, "R3 load-only downgrade");
    do_insert(A + 16'h20, 1);
    do_probe(A + 1, 3, "R5 ext read after store");
    chk("R5 hit", last_hit, 1);
    chk("R4 oldest", last_idx, 0);

    do_insert(B, 0);
    do_insert(C + 8, 0);
    do_insert(B + 4, 1);
    chk("R1 dedup not full", full, 0);
    do_insert(D, 0);
    do_insert(F5, 0);
    chk("R7 full set", full, 1);
    do_insert(F6, 1);
    do_probe(F6, 0, "R7 dropped insert");
    chk("R7 miss", last_hit, 0);
    @(negedge clk);
    prb_addr = C; prb_kind = 0; prb_valid = 0;
    #1 chk("R10 no probe no rollback", rb_valid, 0);
    do_probe(C, 1, "R2 replace hit");
    chk("R2 hit", last_hit, 1);
    chk("R4 target", last_idx, 1);
    chk("R8 full cleared", full, 0);
    do_probe(D, 0, "R8 younger removed");
    chk("R8 D miss", last_hit, 0);
    do_release();
    do_probe(B, 0, "R8 trimmed then R6 freed");
    chk("R6 B miss", last_hit, 0);

    do_insert(G, 0);
    do_insert(G + 2, 0);
    do_release();
    do_probe(G, 2, "R3 downgrade load-only");
    do_probe(G, 0, "R6 kept after other release");
    chk("R6 hit", last_hit, 1);
    chk("R6 oldest", last_idx, 1);

    for (int n = 0; n < 600; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (IW'(nxt - mhead) >= 12 || (lf[1:0] == 2'd0 && mhead != nxt))
        do_release();
      else if (lf[1:0] == 2'd1 || lf[1:0] == 2'd3)
        do_insert({lf[10:8] % 6, lf[5:0]} << 0 | (16'(lf[10:8] % 6) << BB), lf[4]);
      else
        do_probe(16'(lf[13:11] % 6) << BB, lf[15:14], "R2 R3 R4 R8 sweep");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule